// File: doc/BRIEF.md
# Virtual Plane Reset Link Tracker

This block carries the reset level of every virtual plane across one multi-root link. The local side presents a vector of per-plane reset levels, one bit per plane, where a 1 means the plane is held in reset. Planes are handled in groups of 16. Whenever a group's local levels differ from the levels the partner last confirmed, the block emits a link-layer reset request for that group. It repeats the request after a programmable timeout until a confirmation comes back that echoes the same group and mask. Reset messages have their own message port beside the transaction path, so transaction credit stalls never hold them back.

On the receive side the block decodes reset requests from the partner and stores the partner's levels in a per-plane vector. When a request newly asserts any plane, the block asks the local buffers to flush those planes. It sends the confirmation only after the flush is reported done. When the link goes down, every stored partner level returns to asserted and all sender state is dropped. After the link comes back, the sender treats the partner as fully in reset and sends again every group that is not fully asserted locally.

Top module: `vplane_reset_link`

## Requirements
- R1: After reset, `peer_lvl` is all ones, `tx_valid` is 0 and `flush_req` is 0 while `local_lvl` is all ones.
- R2: Each sent message carries `tx_type` equal to the parameter `MSG_TYPE` (default 8'h3A), `tx_ack` = 0 for a request or 1 for a confirmation, `tx_grp` = g and `tx_mask` bit i = level of plane 16g+i.
- R3: A local change in group g produces a request for g with the current local mask, valid at the output one cycle after the change is sampled.
- R4: When several groups need sending, requests leave in ascending group order, one per accepted output cycle.
- R5: A request without a matching confirmation is sent again `retry_limit`+1 cycles after its previous launch.
- R6: A confirmation stops the retries only if its group and mask equal those of the outstanding request. A confirmation with any other mask has no effect.
- R7: A received request updates the partner levels of its group one cycle later. If it asserts no new plane, the confirmation with the same group and mask is valid one cycle after that.
- R8: A request that asserts new planes raises `flush_req` one cycle later, with `flush_grp` = g and `flush_mask` = the newly asserted planes only. The confirmation is withheld until `flush_done` is sampled high and is valid one cycle after `flush_req` falls.
- R9: A request received while an earlier one is still flushing or awaiting its confirmation slot is dropped and changes no partner level.
- R10: A received message whose type byte differs from `MSG_TYPE` is ignored.
- R11: While `link_up` is low, `peer_lvl` becomes all ones and `tx_valid` is 0. After the link returns, each group whose local mask is not all ones is sent again in ascending order.
- R12: While `tx_valid` is high and `tx_ready` is low, the output message holds stable and no lower group can preempt it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link is up; low clears partner state |
| retry_limit | input | TIMER_W | Cycles to wait for a confirmation before resending |
| local_lvl | input | NUM_PLANES | Local reset level per plane |
| tx_ready | input | 1 | Link layer accepts the output message |
| tx_valid | output | 1 | Output message valid |
| tx_type | output | 8 | Message type byte |
| tx_ack | output | 1 | 0 = request, 1 = confirmation |
| tx_grp | output | GIDX_W | Plane group index |
| tx_mask | output | GROUP_SIZE | Reset levels of the group |
| rx_valid | input | 1 | Received message valid |
| rx_type | input | 8 | Received type byte |
| rx_ack | input | 1 | 0 = request, 1 = confirmation |
| rx_grp | input | GIDX_W | Received group index |
| rx_mask | input | GROUP_SIZE | Received levels |
| peer_lvl | output | NUM_PLANES | Stored partner reset level per plane |
| flush_req | output | 1 | Flush request to the plane buffers |
| flush_grp | output | GIDX_W | Group to flush |
| flush_mask | output | GROUP_SIZE | Newly asserted planes to flush |
| flush_done | input | 1 | Flush finished |

## Verification
Every result has a fixed delay. A local change shows up as a request one cycle later. A received request changes `peer_lvl` and `flush_req` one cycle later, and its confirmation follows one cycle after that, or one cycle after the flush ends. A resend comes `retry_limit`+1 cycles after the previous launch. The bench drives inputs on the falling edge and reads results on the falling edge at exactly those offsets, and it measures retry spacing with a cycle counter. A behavioural model of the partner vector is updated just after each rising edge that should change it and is compared with `peer_lvl` on every falling edge, which covers dropped, foreign and link-down cases as well.

// File: rtl/prst_pkg.sv
`timescale 1ns/1ps
package prst_pkg;
  // receive-side handling phase
  typedef enum logic [1:0] {
    RXS_IDLE  = 2'd0,
    RXS_FLUSH = 2'd1,
    RXS_CONF  = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/prst_tx_sched.sv
`timescale 1ns/1ps
module prst_tx_sched #(
  parameter int NG  = 16,
  parameter int GW  = 16,
  parameter int TW  = 16,
  parameter int GIW = $clog2(NG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            link_up,
  input  logic [NG*GW-1:0] loc_lvl,
  input  logic [TW-1:0]   retry_limit,
  input  logic            ack_valid,
  input  logic [GIW-1:0]  ack_grp,
  input  logic [GW-1:0]   ack_mask,
  input  logic            cnf_pend,
  input  logic [GIW-1:0]  cnf_grp,
  input  logic [GW-1:0]   cnf_mask,
  output logic            cnf_take,
  input  logic            tx_ready,
  output logic            tx_valid,
  output logic            tx_ack,
  output logic [GIW-1:0]  tx_grp,
  output logic [GW-1:0]   tx_mask
);
  logic [GW-1:0] loc_g  [NG];
  logic [GW-1:0] conf_q [NG];
  logic [GW-1:0] reqm_q [NG];
  logic [TW-1:0] tmr_q  [NG];
  logic [NG-1:0] pend_q;
  logic [NG-1:0] need;
  logic [NG-1:0] ack_hit;
  logic [GIW-1:0] pick;
  logic           any_need;
  logic           load_en;
  logic           launch;

  assign load_en  = link_up && (!tx_valid || tx_ready);
  assign cnf_take = load_en && cnf_pend;
  assign launch   = load_en && !cnf_pend && any_need;

  // lowest group wins
  always_comb begin
    pick     = '0;
    any_need = |need;
    for (int i = NG - 1; i >= 0; i--) begin
      if (need[i]) pick = GIW'(i);
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic expired;
    assign loc_g[g]   = loc_lvl[g*GW +: GW];
    assign expired    = tmr_q[g] >= retry_limit;
    assign ack_hit[g] = ack_valid && (ack_grp == GIW'(g)) && pend_q[g]
                        && (ack_mask == reqm_q[g]);
    assign need[g]    = !ack_hit[g] &&
                        (pend_q[g] ? expired : (loc_g[g] != conf_q[g]));

    always_ff @(posedge clk) begin
      if (rst || !link_up) begin
        conf_q[g] <= '1;
        reqm_q[g] <= '0;
        pend_q[g] <= 1'b0;
        tmr_q[g]  <= '0;
      end else if (ack_hit[g]) begin
        conf_q[g] <= reqm_q[g];
        pend_q[g] <= 1'b0;
        tmr_q[g]  <= '0;
      end else if (launch && (pick == GIW'(g))) begin
        reqm_q[g] <= loc_g[g];
        pend_q[g] <= 1'b1;
        tmr_q[g]  <= '0;
      end else if (pend_q[g] && !expired) begin
        tmr_q[g]  <= tmr_q[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      tx_valid <= 1'b0;
      tx_ack   <= 1'b0;
      tx_grp   <= '0;
      tx_mask  <= '0;
    end else if (load_en) begin
      if (cnf_pend) begin
        tx_valid <= 1'b1;
        tx_ack   <= 1'b1;
        tx_grp   <= cnf_grp;
        tx_mask  <= cnf_mask;
      end else if (any_need) begin
        tx_valid <= 1'b1;
        tx_ack   <= 1'b0;
        tx_grp   <= pick;
        tx_mask  <= loc_g[pick];
      end else begin
        tx_valid <= 1'b0;
      end
    end
  end

  // R12: a stalled message must not change
  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && link_up) |=>
      (!link_up || (tx_valid && $stable(tx_grp) && $stable(tx_mask) && $stable(tx_ack))));
endmodule

// File: rtl/prst_rx_apply.sv
`timescale 1ns/1ps
module prst_rx_apply
  import prst_pkg::*;
#(
  parameter int NG  = 16,
  parameter int GW  = 16,
  parameter int GIW = $clog2(NG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             req_valid,
  input  logic [GIW-1:0]   req_grp,
  input  logic [GW-1:0]    req_mask,
  output logic [NG*GW-1:0] peer_lvl,
  output logic             flush_req,
  output logic [GIW-1:0]   flush_grp,
  output logic [GW-1:0]    flush_mask,
  input  logic             flush_done,
  output logic             cnf_pend,
  output logic [GIW-1:0]   cnf_grp,
  output logic [GW-1:0]    cnf_mask,
  input  logic             cnf_take
);
  rx_phase_e     phase_q;
  logic [GW-1:0] peer_q [NG];
  logic [GW-1:0] hold_mask_q;
  logic [GIW-1:0] hold_grp_q;
  logic [GW-1:0] rise;

  assign rise      = req_mask & ~peer_q[req_grp];
  assign cnf_grp   = hold_grp_q;
  assign cnf_mask  = hold_mask_q;
  assign flush_grp = hold_grp_q;

  for (genvar g = 0; g < NG; g++) begin : g_out
    assign peer_lvl[g*GW +: GW] = peer_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      for (int i = 0; i < NG; i++) peer_q[i] <= '1;
      phase_q     <= RXS_IDLE;
      flush_req   <= 1'b0;
      flush_mask  <= '0;
      cnf_pend    <= 1'b0;
      hold_grp_q  <= '0;
      hold_mask_q <= '0;
    end else begin
      case (phase_q)
        RXS_IDLE: begin
          if (req_valid) begin
            peer_q[req_grp] <= req_mask;
            hold_grp_q      <= req_grp;
            hold_mask_q     <= req_mask;
            if (|rise) begin
              flush_req  <= 1'b1;
              flush_mask <= rise;
              phase_q    <= RXS_FLUSH;
            end else begin
              cnf_pend   <= 1'b1;
              phase_q    <= RXS_CONF;
            end
          end
        end
        RXS_FLUSH: begin
          if (flush_done) begin
            flush_req <= 1'b0;
            cnf_pend  <= 1'b1;
            phase_q   <= RXS_CONF;
          end
        end
        default: begin
          if (cnf_take) begin
            cnf_pend <= 1'b0;
            phase_q  <= RXS_IDLE;
          end
        end
      endcase
    end
  end

  assert_link_down_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (&peer_lvl));

  assert_flush_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_done && link_up) |=>
      (!link_up || (flush_req && $stable(flush_grp) && $stable(flush_mask))));

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
    ((phase_q != RXS_IDLE) && link_up) |=> (!link_up || $stable(peer_lvl)));
endmodule

// File: rtl/vplane_reset_link.sv
`timescale 1ns/1ps
module vplane_reset_link #(
  parameter int          NUM_PLANES = 256,
  parameter int          GROUP_SIZE = 16,
  parameter int          TIMER_W    = 16,
  parameter logic [7:0]  MSG_TYPE   = 8'h3A,
  parameter int          GIDX_W     = $clog2(NUM_PLANES / GROUP_SIZE)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  link_up,
  input  logic [TIMER_W-1:0]    retry_limit,
  input  logic [NUM_PLANES-1:0] local_lvl,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic [7:0]            tx_type,
  output logic                  tx_ack,
  output logic [GIDX_W-1:0]     tx_grp,
  output logic [GROUP_SIZE-1:0] tx_mask,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_type,
  input  logic                  rx_ack,
  input  logic [GIDX_W-1:0]     rx_grp,
  input  logic [GROUP_SIZE-1:0] rx_mask,
  output logic [NUM_PLANES-1:0] peer_lvl,
  output logic                  flush_req,
  output logic [GIDX_W-1:0]     flush_grp,
  output logic [GROUP_SIZE-1:0] flush_mask,
  input  logic                  flush_done
);
  localparam int NUM_GROUPS = NUM_PLANES / GROUP_SIZE;

  logic                  ours;
  logic                  in_req;
  logic                  in_ack;
  logic                  cnf_pend;
  logic                  cnf_take;
  logic [GIDX_W-1:0]     cnf_grp;
  logic [GROUP_SIZE-1:0] cnf_mask;

  assign ours    = rx_valid && (rx_type == MSG_TYPE);
  assign in_req  = ours && !rx_ack;
  assign in_ack  = ours && rx_ack;
  assign tx_type = MSG_TYPE;

  prst_tx_sched #(
    .NG(NUM_GROUPS), .GW(GROUP_SIZE), .TW(TIMER_W), .GIW(GIDX_W)
  ) u_tx (
    .clk(clk), .rst(rst), .link_up(link_up),
    .loc_lvl(local_lvl), .retry_limit(retry_limit),
    .ack_valid(in_ack), .ack_grp(rx_grp), .ack_mask(rx_mask),
    .cnf_pend(cnf_pend), .cnf_grp(cnf_grp), .cnf_mask(cnf_mask),
    .cnf_take(cnf_take),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_ack(tx_ack),
    .tx_grp(tx_grp), .tx_mask(tx_mask)
  );

  prst_rx_apply #(
    .NG(NUM_GROUPS), .GW(GROUP_SIZE), .GIW(GIDX_W)
  ) u_rx (
    .clk(clk), .rst(rst), .link_up(link_up),
    .req_valid(in_req), .req_grp(rx_grp), .req_mask(rx_mask),
    .peer_lvl(peer_lvl),
    .flush_req(flush_req), .flush_grp(flush_grp), .flush_mask(flush_mask),
    .flush_done(flush_done),
    .cnf_pend(cnf_pend), .cnf_grp(cnf_grp), .cnf_mask(cnf_mask),
    .cnf_take(cnf_take)
  );

  assert_foreign_type_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (rx_type != MSG_TYPE) && link_up) |=> (!link_up || $stable(peer_lvl)));
endmodule

// File: tb/vplane_reset_link_bench.sv
`timescale 1ns/1ps
module vplane_reset_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 12;
  localparam logic [7:0] TYP = 8'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b1;
  logic [15:0] retry_limit = 16'(L);
  logic [255:0] local_lvl = '1;
  logic tx_ready = 1'b1;
  logic tx_valid, tx_ack;
  logic [7:0] tx_type;
  logic [3:0] tx_grp;
  logic [15:0] tx_mask;
  logic rx_valid = 1'b0;
  logic [7:0] rx_type = '0;
  logic rx_ack = 1'b0;
  logic [3:0] rx_grp = '0;
  logic [15:0] rx_mask = '0;
  logic [255:0] peer_lvl;
  logic flush_req;
  logic [3:0] flush_grp;
  logic [15:0] flush_mask;
  logic flush_done = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  logic [255:0] m_peer = '1;

  vplane_reset_link u_vplane_reset_link (
    .clk(clk), .rst(rst), .link_up(link_up), .retry_limit(retry_limit),
    .local_lvl(local_lvl), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_type(tx_type), .tx_ack(tx_ack), .tx_grp(tx_grp), .tx_mask(tx_mask),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_ack(rx_ack), .rx_grp(rx_grp),
    .rx_mask(rx_mask), .peer_lvl(peer_lvl), .flush_req(flush_req),
    .flush_grp(flush_grp), .flush_mask(flush_mask), .flush_done(flush_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // partner-vector model compared every cycle (R7, R9, R10, R11)
  always @(negedge clk) begin
    if (cmp_en) begin
      tests++;
      if (peer_lvl !== m_peer) begin
        fails++;
        $display("FAIL R7 peer model: actual %h expected %h", peer_lvl, m_peer);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_msg(input string tag, input logic ack, input int g, input logic [15:0] m);
    chk({tag, " valid"}, 32'(tx_valid), 32'd1);
    chk({tag, " type"},  32'(tx_type), 32'(TYP));
    chk({tag, " kind"},  32'(tx_ack), 32'(ack));
    chk({tag, " group"}, 32'(tx_grp), 32'(g));
    chk({tag, " mask"},  32'(tx_mask), 32'(m));
  endtask

  task automatic send_rx(input logic ack, input int g, input logic [15:0] m,
                         input logic [7:0] ty, input bit upd);
    rx_valid = 1'b1; rx_ack = ack; rx_grp = 4'(g); rx_mask = m; rx_type = ty;
    @(posedge clk);
    #1;
    if (upd) m_peer[g*16 +: 16] = m;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0;
    int cnt;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    cmp_en = 1'b1;
    chk("R1 tx idle", 32'(tx_valid), 0);
    chk("R1 flush idle", 32'(flush_req), 0);
    chk("R1 peer all asserted", 32'(&peer_lvl), 1);

    // R3 / R4 / R2: two groups change together
    local_lvl[16] = 1'b0;
    local_lvl[53] = 1'b0;
    tick();
    t0 = cyc;
    chk_msg("R3 first request", 1'b0, 1, 16'hFFFE);
    tick();
    chk_msg("R4 second request", 1'b0, 3, 16'hFFDF);
    tick();
    chk("R4 nothing more", 32'(tx_valid), 0);

    // R6: wrong mask confirm has no effect, R5: retry spacing
    send_rx(1'b1, 1, 16'hFFFF, TYP, 1'b0);
    cnt = 0;
    while (!tx_valid && cnt < 100) begin tick(); cnt++; end
    chk("R5 retry delay", 32'(cyc - t0), 32'(L + 1));
    chk_msg("R6 resend after bad confirm", 1'b0, 1, 16'hFFFE);
    tick();
    chk_msg("R5 resend group3", 1'b0, 3, 16'hFFDF);

    // R6: matching confirms stop retries
    send_rx(1'b1, 1, 16'hFFFE, TYP, 1'b0);
    send_rx(1'b1, 3, 16'hFFDF, TYP, 1'b0);
    cnt = 0;
    for (int i = 0; i < 3 * L; i++) begin tick(); if (tx_valid) cnt++; end
    chk("R6 no retry after confirm", 32'(cnt), 0);

    // R12: stall holds message
    tx_ready = 1'b0;
    local_lvl[39] = 1'b0;
    tick();
    chk_msg("R12 stalled request", 1'b0, 2, 16'hFF7F);
    local_lvl[0] = 1'b0;
    repeat (3) tick();
    chk_msg("R12 held", 1'b0, 2, 16'hFF7F);
    tx_ready = 1'b1;
    tick();
    chk_msg("R12 next after release", 1'b0, 0, 16'hFFFE);
    send_rx(1'b1, 2, 16'hFF7F, TYP, 1'b0);
    send_rx(1'b1, 0, 16'hFFFE, TYP, 1'b0);
    cnt = 0;
    for (int i = 0; i < 2 * L; i++) begin tick(); if (tx_valid) cnt++; end
    chk("R12 quiet after confirms", 32'(cnt), 0);

    // R7: clearing request, immediate confirm
    send_rx(1'b0, 4, 16'hFF0F, TYP, 1'b1);
    chk("R7 no flush", 32'(flush_req), 0);
    tick();
    chk_msg("R7 confirm echo", 1'b1, 4, 16'hFF0F);
    tick();
    chk("R7 confirm once", 32'(tx_valid), 0);

    // R8: asserting request waits for flush; R9: request while busy dropped
    send_rx(1'b0, 4, 16'hFFFF, TYP, 1'b1);
    chk("R8 flush raised", 32'(flush_req), 1);
    chk("R8 flush group", 32'(flush_grp), 4);
    chk("R8 flush mask", 32'(flush_mask), 32'h00F0);
    send_rx(1'b0, 5, 16'h0000, TYP, 1'b0);
    tick();
    chk("R8 confirm withheld", 32'(tx_valid), 0);
    chk("R8 flush still up", 32'(flush_req), 1);
    chk("R9 dropped request", 32'(peer_lvl[95:80]), 32'hFFFF);
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
    chk("R8 flush cleared", 32'(flush_req), 0);
    chk("R8 no confirm yet", 32'(tx_valid), 0);
    tick();
    chk_msg("R8 confirm after flush", 1'b1, 4, 16'hFFFF);
    tick();

    // R10: foreign type byte
    send_rx(1'b0, 6, 16'h0000, TYP ^ 8'h01, 1'b0);
    tick();
    chk("R10 no confirm", 32'(tx_valid), 0);
    chk("R10 peer untouched", 32'(peer_lvl[111:96]), 32'hFFFF);

    // R11: link down and back up
    send_rx(1'b0, 7, 16'h0000, TYP, 1'b1);
    tick();
    chk_msg("R11 pre confirm", 1'b1, 7, 16'h0000);
    tick();
    link_up = 1'b0;
    @(posedge clk);
    #1;
    m_peer = '1;
    @(negedge clk);
    chk("R11 tx idle", 32'(tx_valid), 0);
    chk("R11 peer all asserted", 32'(&peer_lvl), 1);
    repeat (3) tick();
    link_up = 1'b1;
    tick();
    chk_msg("R11 resend g0", 1'b0, 0, 16'hFFFE);
    tick();
    chk_msg("R11 resend g1", 1'b0, 1, 16'hFFFE);
    tick();
    chk_msg("R11 resend g2", 1'b0, 2, 16'hFF7F);
    tick();
    chk_msg("R11 resend g3", 1'b0, 3, 16'hFFDF);
    tick();
    chk("R11 done", 32'(tx_valid), 0);

    cmp_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule